// File: doc/BRIEF.md
# Programmable Timer with Target Compare

A single 16-bit up-counting timer channel with three registers behind a small read/write bus: a count register, a mode register and a target register. The counter advances on a clock enable chosen by the mode register: every system clock, an external tick strobe, or every eighth system clock. It can restart from zero each time it reaches the target, or keep running through the target to the top of its range and wrap to zero.

Target and wrap events set sticky status bits in the mode word. Reading the mode register clears two of them. Each event can also drive a one-cycle interrupt pulse, either only for the first event after a mode write or for every event. A parameter picks the channel variant. Variants 0 and 1 take the external tick as their alternate clock. Variant 2 has an eight-way prescaler and halts in two of its sync settings.

The counter sequencer has three states. `ST_SEEK_TGT`: the count is below the target, and the next match raises a target event. `ST_SEEK_WRAP`: the count heads for 0xFFFF. `ST_STOPPED`: the count is frozen. Its transitions are:
- mode write: to STOPPED when the halt condition holds, otherwise to SEEK_TGT if the target is nonzero, else to SEEK_WRAP.
- count or target write: to SEEK_TGT if count < target, else to SEEK_WRAP. STOPPED stays STOPPED.
- target match in SEEK_TGT: stay in SEEK_TGT with restart, otherwise go to SEEK_WRAP.
- wrap in SEEK_WRAP: to SEEK_TGT if the target is nonzero, otherwise stay in SEEK_WRAP.

The interrupt sequencer has two states. `ARM_READY` moves to `ARM_SPENT` on a pulse. A mode write returns it to `ARM_READY`.

Top module: `prog_timer`

## Requirements
- R1: During and right after reset, the count, mode and target read as 0 and irq is low.
- R2: Bus address 0 selects the count, 1 the mode and 2 the target. A write stores only bits 15:0 of the 32-bit write data, and read data is 16 bits.
- R3: The count increments by one per enabled tick and wraps from 0xFFFF to 0. A wrap sets mode bit 12 and mode bit 10.
- R4: With mode bit 3 set, a tick that brings the count to the target loads 0 instead. With bit 3 clear, the count continues past the target. Either way, reaching the target sets mode bit 11 and bit 10.
- R5: Any mode write loads mode bits 9:0, clears the count to 0, clears bits 10, 11 and 12, and re-arms the interrupt.
- R6: A mode read returns the current mode word and then clears bits 11 and 12, leaving bit 10. An event in the same cycle as the read leaves its bit set.
- R7: irq is a one-cycle pulse in the cycle after a target event with mode bit 4 set, or after a wrap event with mode bit 5 set.
- R8: With mode bit 6 clear, only the first qualifying event after a mode write pulses irq. With bit 6 set, every qualifying event pulses irq.
- R9: In variants 0 and 1, mode bit 8 selects the ext_tick strobe as the counting enable. Otherwise the count advances every clock.
- R10: In variant 2, mode bit 9 selects a tick every eighth clock. The first tick comes eight clocks after the mode write.
- R11: In variant 2, mode bit 0 set with bits 2:1 equal to 00 or 11 freezes the count until the next mode write. Sync values 01 and 10 count normally, and variants 0 and 1 ignore the sync bits.
- R12: A target write leaves the count unchanged. A count write loads the written value.
- R13: A register write in the same cycle as a tick takes priority, and that tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_tick | input | 1 | External counting strobe, synchronous to clk |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (triggers mode read-clear) |
| bus_addr | input | 2 | Register address: 0 count, 1 mode, 2 target |
| bus_wdata | input | 32 | Write data, low 16 bits used |
| bus_rdata | output | 16 | Combinational read data |
| irq | output | 1 | Interrupt pulse |

## Verification
Two pairs of functions can fall in the same cycle, and the bench provokes both on purpose.

For the first pair, the bench raises a tick strobe during the same cycle as a count, mode or target write. It then judges that the written value, not an incremented one, is read back.

For the second pair, it sets the count one step below the target and issues a mode read in the very cycle that tick produces the target match. The read must return the pre-event word. The following read must show the target bit still set, and only a third read may show it cleared.

// File: rtl/prog_timer_pkg.sv
package prog_timer_pkg;

    typedef enum logic [1:0] {
        ST_SEEK_TGT  = 2'd0,
        ST_SEEK_WRAP = 2'd1,
        ST_STOPPED   = 2'd2
    } tmr_state_t;

    typedef enum logic {
        ARM_READY = 1'b0,
        ARM_SPENT = 1'b1
    } irq_arm_t;

    localparam int VAR_PIXEL = 0;
    localparam int VAR_LINE  = 1;
    localparam int VAR_DIV8  = 2;

    localparam int MB_SYNC_EN  = 0;
    localparam int MB_RESTART  = 3;
    localparam int MB_IRQ_TGT  = 4;
    localparam int MB_IRQ_WRAP = 5;
    localparam int MB_IRQ_REP  = 6;
    localparam int MB_SRC_EXT  = 8;
    localparam int MB_SRC_DIV  = 9;
    localparam int MB_EVENT    = 10;
    localparam int MB_HIT_TGT  = 11;
    localparam int MB_HIT_WRAP = 12;
    localparam int CFG_W       = 10;

    localparam logic [1:0] A_COUNT  = 2'd0;
    localparam logic [1:0] A_MODE   = 2'd1;
    localparam logic [1:0] A_TARGET = 2'd2;

endpackage

// File: rtl/prog_timer_regs.sv
module prog_timer_regs
    import prog_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0] count,
    input  logic             ev_tgt,
    input  logic             ev_wrap,
    output logic [CNT_W-1:0] rdata,
    output logic [CNT_W-1:0] wval,
    output logic [CNT_W-1:0] target,
    output logic             mode_wr,
    output logic             count_wr,
    output logic             tgt_wr,
    output logic             restart,
    output logic             irq_tgt_en,
    output logic             irq_wrap_en,
    output logic             irq_rep,
    output logic             src_ext,
    output logic             src_div,
    output logic             flag_tgt,
    output logic             flag_wrap
);

    logic [CFG_W-1:0] cfg_q;
    logic [CNT_W-1:0] tgt_q;
    logic             flag_evt;
    logic             wr_stb;
    logic             rd_mode;
    logic [CNT_W-1:0] mode_word;
    logic             unused_hi;

    assign wval      = bus_wdata[CNT_W-1:0];
    assign unused_hi = ^bus_wdata[BUS_W-1:CNT_W];
    assign wr_stb    = bus_sel & bus_wr;
    assign mode_wr   = wr_stb & (bus_addr == A_MODE);
    assign count_wr  = wr_stb & (bus_addr == A_COUNT);
    assign tgt_wr    = wr_stb & (bus_addr == A_TARGET);
    assign rd_mode   = bus_sel & bus_rd & ~bus_wr & (bus_addr == A_MODE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            tgt_q     <= '0;
            flag_evt  <= 1'b0;
            flag_tgt  <= 1'b0;
            flag_wrap <= 1'b0;
        end else begin
            if (mode_wr) cfg_q <= wval[CFG_W-1:0];
            if (tgt_wr)  tgt_q <= wval;
            if (mode_wr) begin
                flag_evt  <= 1'b0;
                flag_tgt  <= 1'b0;
                flag_wrap <= 1'b0;
            end else begin
                flag_evt  <= flag_evt | ev_tgt | ev_wrap;
                flag_tgt  <= (flag_tgt  & ~rd_mode) | ev_tgt;
                flag_wrap <= (flag_wrap & ~rd_mode) | ev_wrap;
            end
        end
    end

    always_comb begin
        mode_word              = '0;
        mode_word[CFG_W-1:0]   = cfg_q;
        mode_word[MB_EVENT]    = flag_evt;
        mode_word[MB_HIT_TGT]  = flag_tgt;
        mode_word[MB_HIT_WRAP] = flag_wrap;
        case (bus_addr)
            A_COUNT:  rdata = count;
            A_MODE:   rdata = mode_word;
            A_TARGET: rdata = tgt_q;
            default:  rdata = '0;
        endcase
    end

    assign target      = tgt_q;
    assign restart     = cfg_q[MB_RESTART];
    assign irq_tgt_en  = cfg_q[MB_IRQ_TGT];
    assign irq_wrap_en = cfg_q[MB_IRQ_WRAP];
    assign irq_rep     = cfg_q[MB_IRQ_REP];
    assign src_ext     = cfg_q[MB_SRC_EXT];
    assign src_div     = cfg_q[MB_SRC_DIV];

endmodule

// File: rtl/prog_timer_tick.sv
module prog_timer_tick
    import prog_timer_pkg::*;
#(
    parameter int VARIANT = VAR_PIXEL,
    parameter int DIV_W   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_wr,
    input  logic src_ext,
    input  logic src_div,
    input  logic ext_tick,
    output logic tick
);

    logic [DIV_W-1:0] pre_q;
    logic             pre_done;

    always_ff @(posedge clk) begin
        if (!rst_n)       pre_q <= '0;
        else if (mode_wr) pre_q <= '0;
        else              pre_q <= pre_q + 1'b1;
    end

    assign pre_done = &pre_q;

    generate
        if (VARIANT == VAR_DIV8) begin : g_div
            logic unused_sel;
            assign unused_sel = src_ext ^ ext_tick;
            assign tick       = src_div ? pre_done : 1'b1;
        end else begin : g_ext
            logic unused_sel;
            assign unused_sel = src_div ^ pre_done;
            assign tick       = src_ext ? ext_tick : 1'b1;
        end
    endgenerate

endmodule

// File: rtl/prog_timer_count.sv
module prog_timer_count
    import prog_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             mode_wr,
    input  logic             count_wr,
    input  logic             tgt_wr,
    input  logic             halt_on_wr,
    input  logic             restart,
    input  logic [CNT_W-1:0] wval,
    input  logic [CNT_W-1:0] target,
    output logic [CNT_W-1:0] count,
    output tmr_state_t       state,
    output logic             ev_tgt,
    output logic             ev_wrap
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    tmr_state_t       state_n;
    logic [CNT_W-1:0] count_n;
    logic [CNT_W-1:0] nxt;
    logic             step;

    assign nxt     = count + 1'b1;
    assign step    = tick & ~(mode_wr | count_wr | tgt_wr) & (state != ST_STOPPED);
    assign ev_tgt  = step & (state == ST_SEEK_TGT)  & (nxt == target);
    assign ev_wrap = step & (state == ST_SEEK_WRAP) & (count == CNT_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_SEEK_WRAP;
            count <= '0;
        end else begin
            state <= state_n;
            count <= count_n;
        end
    end

    always_comb begin
        state_n = state;
        count_n = count;
        if (mode_wr) begin
            count_n = '0;
            if (halt_on_wr)          state_n = ST_STOPPED;
            else if (target != '0)   state_n = ST_SEEK_TGT;
            else                     state_n = ST_SEEK_WRAP;
        end else if (count_wr) begin
            count_n = wval;
            if (state != ST_STOPPED)
                state_n = (wval < target) ? ST_SEEK_TGT : ST_SEEK_WRAP;
        end else if (tgt_wr) begin
            if (state != ST_STOPPED)
                state_n = (count < wval) ? ST_SEEK_TGT : ST_SEEK_WRAP;
        end else if (step) begin
            unique case (state)
                ST_SEEK_TGT: begin
                    if (ev_tgt) begin
                        count_n = restart ? '0 : nxt;
                        state_n = restart ? ST_SEEK_TGT : ST_SEEK_WRAP;
                    end else begin
                        count_n = nxt;
                    end
                end
                ST_SEEK_WRAP: begin
                    if (ev_wrap) begin
                        count_n = '0;
                        state_n = (target != '0) ? ST_SEEK_TGT : ST_SEEK_WRAP;
                    end else begin
                        count_n = nxt;
                    end
                end
                default: begin
                    state_n = state;
                end
            endcase
        end
    end

endmodule

// File: rtl/prog_timer_irq.sv
module prog_timer_irq
    import prog_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_wr,
    input  logic ev_tgt,
    input  logic ev_wrap,
    input  logic irq_tgt_en,
    input  logic irq_wrap_en,
    input  logic irq_rep,
    output logic irq
);

    irq_arm_t arm_q;
    irq_arm_t arm_n;
    logic     fire;

    assign fire = ((ev_tgt & irq_tgt_en) | (ev_wrap & irq_wrap_en))
                & (irq_rep | (arm_q == ARM_READY));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q <= ARM_READY;
            irq   <= 1'b0;
        end else begin
            arm_q <= arm_n;
            irq   <= fire;
        end
    end

    always_comb begin
        arm_n = arm_q;
        if (mode_wr) begin
            arm_n = ARM_READY;
        end else begin
            unique case (arm_q)
                ARM_READY: if (fire) arm_n = ARM_SPENT;
                ARM_SPENT: arm_n = ARM_SPENT;
                default:   arm_n = ARM_READY;
            endcase
        end
    end

endmodule

// File: rtl/prog_timer.sv
module prog_timer
    import prog_timer_pkg::*;
#(
    parameter int VARIANT = VAR_PIXEL,
    parameter int CNT_W   = 16,
    parameter int BUS_W   = 32,
    parameter int DIV_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_tick,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq
);

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] wval;
    logic [CNT_W-1:0] target;
    logic             mode_wr, count_wr, tgt_wr;
    logic             restart, irq_tgt_en, irq_wrap_en, irq_rep;
    logic             src_ext, src_div;
    logic             flag_tgt, flag_wrap;
    logic             tick, ev_tgt, ev_wrap;
    logic             halt_on_wr;
    tmr_state_t       state;

    assign halt_on_wr = (VARIANT == VAR_DIV8) && wval[MB_SYNC_EN]
                      && ((wval[2:1] == 2'b00) || (wval[2:1] == 2'b11));

    prog_timer_regs #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .count(count), .ev_tgt(ev_tgt), .ev_wrap(ev_wrap),
        .rdata(bus_rdata), .wval(wval), .target(target),
        .mode_wr(mode_wr), .count_wr(count_wr), .tgt_wr(tgt_wr),
        .restart(restart), .irq_tgt_en(irq_tgt_en), .irq_wrap_en(irq_wrap_en),
        .irq_rep(irq_rep), .src_ext(src_ext), .src_div(src_div),
        .flag_tgt(flag_tgt), .flag_wrap(flag_wrap)
    );

    prog_timer_tick #(.VARIANT(VARIANT), .DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .src_ext(src_ext),
        .src_div(src_div), .ext_tick(ext_tick), .tick(tick)
    );

    prog_timer_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode_wr(mode_wr),
        .count_wr(count_wr), .tgt_wr(tgt_wr), .halt_on_wr(halt_on_wr),
        .restart(restart), .wval(wval), .target(target), .count(count),
        .state(state), .ev_tgt(ev_tgt), .ev_wrap(ev_wrap)
    );

    prog_timer_irq u_irq (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .ev_tgt(ev_tgt),
        .ev_wrap(ev_wrap), .irq_tgt_en(irq_tgt_en), .irq_wrap_en(irq_wrap_en),
        .irq_rep(irq_rep), .irq(irq)
    );

endmodule

// File: rtl/prog_timer_chk.sv
module prog_timer_chk
    import prog_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_wr,
    input logic             count_wr,
    input logic             tgt_wr,
    input logic [CNT_W-1:0] count,
    input tmr_state_t       state,
    input logic             ev_tgt,
    input logic             ev_wrap,
    input logic             flag_tgt,
    input logic             flag_wrap,
    input logic             irq
);

    p_mode_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (count == '0));

    p_target_keeps_count_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_wr |=> (count == $past(count)));

    p_halt_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOPPED && !mode_wr && !count_wr) |=> $stable(count));

    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ev_tgt || ev_wrap));

    p_tgt_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tgt |=> flag_tgt);

    p_wrap_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wrap |=> flag_wrap);

    p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_wr && !count_wr && !ev_tgt && !ev_wrap)
        |=> ((count == $past(count)) || (count == CNT_W'($past(count) + 1'b1))));

endmodule

bind prog_timer prog_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .count_wr(count_wr),
    .tgt_wr(tgt_wr), .count(count), .state(state), .ev_tgt(ev_tgt),
    .ev_wrap(ev_wrap), .flag_tgt(flag_tgt), .flag_wrap(flag_wrap), .irq(irq)
);

// File: tb/prog_timer_tb.sv
`timescale 1ns/1ps
module prog_timer_tb;
    import prog_timer_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext = 1'b0;
    logic        sel = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = 32'd0;
    logic [15:0] rdata_a, rdata_b;
    logic        irq_a, irq_b;

    int vectors = 0;
    int miscompares = 0;
    int irq_cnt = 0;
    int run_len = 0;
    int max_run = 0;
    int base;

    typedef struct {
        logic        chk_a;
        logic [15:0] exp_a;
        logic        chk_b;
        logic [15:0] exp_b;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    prog_timer #(.VARIANT(VAR_PIXEL)) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_tick(ext), .bus_sel(sel), .bus_wr(wr),
        .bus_rd(rd), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_a),
        .irq(irq_a)
    );

    prog_timer #(.VARIANT(VAR_DIV8)) u_div (
        .clk(clk), .rst_n(rst_n), .ext_tick(ext), .bus_sel(sel), .bus_wr(wr),
        .bus_rd(rd), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_b),
        .irq(irq_b)
    );

    task automatic check(input int got, input int exp, input string tag);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Monitor: samples 1 ns after each falling edge
    always @(negedge clk) begin
        item_t it;
        #1;
        if (irq_a === 1'b1) begin
            irq_cnt++;
            run_len++;
            if (run_len > max_run) max_run = run_len;
        end else begin
            run_len = 0;
        end
        if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            if (it.chk_a) check(int'(rdata_a), int'(it.exp_a), {it.tag, " u_dut"});
            if (it.chk_b) check(int'(rdata_b), int'(it.exp_b), {it.tag, " u_div"});
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d, input logic with_tick);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d; ext = with_tick;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; ext = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, input logic ca, input logic [15:0] ea,
                            input logic cb, input logic [15:0] eb, input string tag,
                            input logic with_tick);
        item_t it;
        @(negedge clk);
        sel = 1'b1; rd = 1'b1; addr = a; ext = with_tick;
        it.chk_a = ca; it.exp_a = ea; it.chk_b = cb; it.exp_b = eb; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        sel = 1'b0; rd = 1'b0; ext = 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext = 1'b1;
            @(negedge clk); ext = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        miscompares++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        // R1: reset state, read while reset is held
        idle(2);
        bus_read(A_COUNT,  1, 16'h0, 1, 16'h0, "R1 count", 0);
        bus_read(A_MODE,   1, 16'h0, 1, 16'h0, "R1 mode", 0);
        bus_read(A_TARGET, 1, 16'h0, 1, 16'h0, "R1 target", 0);
        idle(1);
        check(int'(irq_a), 0, "R1 irq");
        rst_n = 1'b1;

        // R9: external strobe source on variant 0, ignored by variant 2
        bus_write(A_MODE, 32'h100, 0);
        idle(5);
        bus_read(A_COUNT, 1, 16'h0, 1, 16'd6, "R9 ext source idle", 0);
        pulse(3);
        bus_read(A_COUNT, 1, 16'd3, 0, 16'h0, "R9 three strobes", 0);

        // R12 / R2: target write keeps count; truncated count load
        bus_write(A_TARGET, 32'd5, 0);
        bus_read(A_COUNT, 1, 16'd3, 0, 16'h0, "R12 target write", 0);
        bus_read(A_TARGET, 1, 16'd5, 1, 16'd5, "R2 target readback", 0);
        bus_write(A_COUNT, 32'h0001_FFFE, 0);
        bus_read(A_COUNT, 1, 16'hFFFE, 0, 16'h0, "R2 truncation", 0);
        pulse(1);
        bus_read(A_COUNT, 1, 16'hFFFF, 0, 16'h0, "R3 top value", 0);
        pulse(1);
        bus_read(A_MODE, 1, 16'h1500, 0, 16'h0, "R3 wrap flags", 0);
        bus_read(A_MODE, 1, 16'h0500, 0, 16'h0, "R6 read clear", 0);
        bus_read(A_COUNT, 1, 16'h0, 0, 16'h0, "R3 wrapped to zero", 0);

        // R4 / R5: restart on target
        bus_write(A_MODE, 32'h108, 0);
        bus_read(A_MODE, 1, 16'h0108, 0, 16'h0, "R5 flags cleared", 0);
        pulse(5);
        bus_read(A_COUNT, 1, 16'h0, 0, 16'h0, "R4 restart at target", 0);
        bus_read(A_MODE, 1, 16'h0D08, 0, 16'h0, "R4 target flag", 0);
        pulse(2);
        bus_read(A_COUNT, 1, 16'd2, 0, 16'h0, "R4 counting after restart", 0);
        bus_write(A_MODE, 32'h100, 0);
        pulse(5);
        bus_read(A_COUNT, 1, 16'd5, 0, 16'h0, "R4 no restart holds target", 0);
        bus_read(A_MODE, 1, 16'h0D00, 0, 16'h0, "R4 flag without restart", 0);
        pulse(1);
        bus_read(A_COUNT, 1, 16'd6, 0, 16'h0, "R4 continues past target", 0);

        // R8: one-shot versus repeat interrupts
        base = irq_cnt;
        bus_write(A_MODE, 32'h118, 0);
        pulse(10);
        idle(1);
        check(irq_cnt - base, 1, "R8 one-shot irq count");
        base = irq_cnt;
        bus_write(A_MODE, 32'h158, 0);
        pulse(10);
        idle(1);
        check(irq_cnt - base, 2, "R8 repeat irq count");

        // R7: wrap interrupt, single-cycle width
        bus_write(A_MODE, 32'h160, 0);
        bus_write(A_COUNT, 32'hFFFF, 0);
        base = irq_cnt;
        pulse(1);
        idle(1);
        check(irq_cnt - base, 1, "R7 wrap irq");
        bus_read(A_COUNT, 1, 16'h0, 0, 16'h0, "R7 count after wrap", 0);
        check(max_run, 1, "R7 pulse width");

        // R13: writes win over a same-cycle tick
        bus_write(A_MODE, 32'h100, 0);
        bus_write(A_COUNT, 32'h10, 1);
        bus_read(A_COUNT, 1, 16'h0010, 0, 16'h0, "R13 count write vs tick", 0);
        bus_write(A_MODE, 32'h100, 1);
        bus_read(A_COUNT, 1, 16'h0, 0, 16'h0, "R13 mode write vs tick", 0);
        bus_write(A_TARGET, 32'd9, 1);
        bus_read(A_COUNT, 1, 16'h0, 0, 16'h0, "R13 target write vs tick", 0);

        // R6: mode read in the same cycle as a target event
        bus_write(A_TARGET, 32'd5, 0);
        bus_write(A_COUNT, 32'd4, 0);
        bus_read(A_MODE, 1, 16'h0100, 0, 16'h0, "R6 read during event", 1);
        bus_read(A_MODE, 1, 16'h0D00, 0, 16'h0, "R6 flag survives read", 0);
        bus_read(A_MODE, 1, 16'h0500, 0, 16'h0, "R6 flag cleared later", 0);

        // R10: divide-by-eight source on variant 2
        bus_write(A_MODE, 32'h200, 0);
        idle(6);
        bus_read(A_COUNT, 0, 16'h0, 1, 16'h0, "R10 before eighth clock", 0);
        bus_read(A_COUNT, 0, 16'h0, 1, 16'd1, "R10 first prescaled tick", 0);

        // R11: sync halt on variant 2 only
        bus_write(A_MODE, 32'h001, 0);
        idle(10);
        bus_read(A_COUNT, 1, 16'd11, 1, 16'h0, "R11 sync mode 0", 0);
        bus_write(A_MODE, 32'h003, 0);
        idle(3);
        bus_read(A_COUNT, 1, 16'd4, 1, 16'd4, "R11 sync mode 1 counts", 0);
        bus_write(A_MODE, 32'h007, 0);
        idle(4);
        bus_read(A_COUNT, 1, 16'd5, 1, 16'h0, "R11 sync mode 3", 0);

        idle(3);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule